// File: doc/BRIEF.md
# Fault-Bypass Look-Ahead XYZ Route Unit

This unit makes the routing decision for one router of a three-dimensional mesh of up to 3x3x3 nodes. When an arriving flit is flagged valid, the unit compares the flit's destination coordinates with the router's own coordinates. It picks one of seven output directions: East, West, North, South, Up, Down or Local. In the same step it works out the coordinates of the neighbour that the flit will reach. The downstream router can use these coordinates at once, so its own decision is ready one hop early.

The unit resolves X first, then Y, then Z. A six-bit flag vector marks each neighbour as faulty or congested. If the hop in the preferred dimension leads to a flagged neighbour, the unit takes a productive hop in another dimension that is still unresolved. The path length therefore stays minimal. If every productive neighbour is flagged, the unit keeps the preferred direction and raises a blocked indication. The result is registered, and it stays unchanged until the next valid flit arrives.

Top module: `route_bypass_xyz`

## Requirements
- R1: The flit is 22 bits. Bit 21 is the tail bit. Bits 20:14 hold the next-port field. Bits 13:12 hold the X destination, bits 11:10 the Y destination and bits 9:8 the Z destination. Bits 7:0 are payload. The output flit equals the captured input flit, except that bits 20:14 are replaced by the chosen port. Every flit carries the destination fields, and the tail bit passes through unchanged.
- R2: The port vector is one-hot in this bit order: bit 0 East, bit 1 West, bit 2 North, bit 3 South, bit 4 Up, bit 5 Down, bit 6 Local. For an X move, a destination greater than the own X coordinate selects East, and a smaller one selects West.
- R3: For a Y move, a greater Y destination selects North and a smaller one selects South. For a Z move, a greater Z destination selects Up and a smaller one selects Down.
- R4: When all three destination coordinates equal the own coordinates, the port is Local, blocked is 0, and the next-node coordinates equal the own coordinates, whatever the flags.
- R5: With no flags set, X is resolved first, then Y, then Z.
- R6: The flag vector marks neighbours in this bit order: bit 0 East, 1 West, 2 North, 3 South, 4 Up, 5 Down. If the preferred neighbour is flagged, the unit picks the first unresolved dimension in X, Y, Z order whose productive neighbour is not flagged. A flagged neighbour is never chosen unless blocked is raised.
- R7: If every productive neighbour is flagged, the port is the preferred one and blocked is 1. Otherwise blocked is 0.
- R8: The next-node coordinates are the own coordinates moved by one step along the chosen direction. East, North and Up add one; West, South and Down subtract one.
- R9: The outputs update on the clock edge after in_valid is high, and out_valid is high for exactly that one cycle. While in_valid is low, all the other outputs hold their values.
- R10: During reset, out_valid, out_port, out_blocked, the next-node coordinates and out_flit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Arriving flit is valid this cycle |
| in_flit | input | 22 | Arriving flit |
| my_x | input | 2 | Own X coordinate |
| my_y | input | 2 | Own Y coordinate |
| my_z | input | 2 | Own Z coordinate |
| nbr_flag | input | 6 | Faulty or congested flag per neighbour (E,W,N,S,U,D) |
| out_valid | output | 1 | One-cycle pulse for a new result |
| out_port | output | 7 | One-hot chosen port (E,W,N,S,U,D,L) |
| out_blocked | output | 1 | All productive neighbours are flagged |
| out_nx | output | 2 | X coordinate of the next node |
| out_ny | output | 2 | Y coordinate of the next node |
| out_nz | output | 2 | Z coordinate of the next node |
| out_flit | output | 22 | Flit with the next-port field rewritten |

## Verification
A wrong priority in the bypass selection shows up at the port and next-node outputs one cycle after the flit is accepted. It appears as a flagged direction being taken, or as a later dimension taken ahead of an earlier free one. A corrupted result register shows as a port vector that is not one-hot. It can also show as a port that changes while in_valid is low, and that is visible in the very next cycle. A wrong blocked decision shows as a blocked flag that disagrees with the flag pattern of the productive neighbours, in the same cycle as the port.

// File: rtl/route_bypass_xyz.sv
module route_bypass_xyz #(
  parameter int CW = 2,
  parameter int PW = 8,
  localparam int FW = 8 + 3*CW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [FW-1:0] in_flit,
  input  logic [CW-1:0] my_x,
  input  logic [CW-1:0] my_y,
  input  logic [CW-1:0] my_z,
  input  logic [5:0]    nbr_flag,
  output logic          out_valid,
  output logic [6:0]    out_port,
  output logic          out_blocked,
  output logic [CW-1:0] out_nx,
  output logic [CW-1:0] out_ny,
  output logic [CW-1:0] out_nz,
  output logic [FW-1:0] out_flit
);
  localparam int ZD_LO = PW;
  localparam int YD_LO = PW + CW;
  localparam int XD_LO = PW + 2*CW;
  localparam int NP_LO = PW + 3*CW;

  localparam logic [6:0] P_E = 7'b0000001;
  localparam logic [6:0] P_W = 7'b0000010;
  localparam logic [6:0] P_N = 7'b0000100;
  localparam logic [6:0] P_S = 7'b0001000;
  localparam logic [6:0] P_U = 7'b0010000;
  localparam logic [6:0] P_D = 7'b0100000;
  localparam logic [6:0] P_L = 7'b1000000;

  logic [CW-1:0] dx, dy, dz;
  assign dx = in_flit[XD_LO +: CW];
  assign dy = in_flit[YD_LO +: CW];
  assign dz = in_flit[ZD_LO +: CW];

  logic need_x, need_y, need_z, go_e, go_n, go_u;
  assign need_x = dx != my_x;
  assign need_y = dy != my_y;
  assign need_z = dz != my_z;
  assign go_e   = dx > my_x;
  assign go_n   = dy > my_y;
  assign go_u   = dz > my_z;

  logic bad_x, bad_y, bad_z;
  assign bad_x = go_e ? nbr_flag[0] : nbr_flag[1];
  assign bad_y = go_n ? nbr_flag[2] : nbr_flag[3];
  assign bad_z = go_u ? nbr_flag[4] : nbr_flag[5];

  logic [6:0] port_x, port_y, port_z;
  assign port_x = go_e ? P_E : P_W;
  assign port_y = go_n ? P_N : P_S;
  assign port_z = go_u ? P_U : P_D;

  logic [6:0] port_d;
  logic       blk_d;
  always_comb begin
    blk_d  = 1'b0;
    port_d = P_L;
    if (need_x && !bad_x)      port_d = port_x;
    else if (need_y && !bad_y) port_d = port_y;
    else if (need_z && !bad_z) port_d = port_z;
    else if (need_x) begin port_d = port_x; blk_d = 1'b1; end
    else if (need_y) begin port_d = port_y; blk_d = 1'b1; end
    else if (need_z) begin port_d = port_z; blk_d = 1'b1; end
  end

  logic [CW-1:0] nx_d, ny_d, nz_d;
  assign nx_d = port_d[0] ? my_x + CW'(1) : port_d[1] ? my_x - CW'(1) : my_x;
  assign ny_d = port_d[2] ? my_y + CW'(1) : port_d[3] ? my_y - CW'(1) : my_y;
  assign nz_d = port_d[4] ? my_z + CW'(1) : port_d[5] ? my_z - CW'(1) : my_z;

  logic [FW-1:0] flit_d;
  always_comb begin
    flit_d = in_flit;
    flit_d[NP_LO +: 7] = port_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_port    <= '0;
      out_blocked <= 1'b0;
      out_nx      <= '0;
      out_ny      <= '0;
      out_nz      <= '0;
      out_flit    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_port    <= port_d;
        out_blocked <= blk_d;
        out_nx      <= nx_d;
        out_ny      <= ny_d;
        out_nz      <= nz_d;
        out_flit    <= flit_d;
      end
    end
  end

  AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_port) == 1); // R2
  AST_FIELD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_flit[NP_LO +: 7] == out_port); // R1
  AST_HOME_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !need_x && !need_y && !need_z |=> out_port == P_L && !out_blocked); // R4
  AST_X_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && need_x && !bad_x |=> out_port[0] || out_port[1]); // R5
  AST_AVOID_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_blocked |-> (out_port[5:0] & $past(nbr_flag)) == 6'b0); // R6
  AST_BLOCK_NOT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_blocked |-> !out_port[6]); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_port) && $stable(out_flit) && $stable(out_blocked)); // R9
endmodule

// File: tb/tb_route_bypass_xyz.sv
`timescale 1ns/1ps
module tb_route_bypass_xyz;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [21:0] in_flit;
  logic [1:0]  my_x, my_y, my_z;
  logic [5:0]  nbr_flag;
  logic        out_valid, out_blocked;
  logic [6:0]  out_port;
  logic [1:0]  out_nx, out_ny, out_nz;
  logic [21:0] out_flit;

  route_bypass_xyz dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .my_x(my_x), .my_y(my_y), .my_z(my_z), .nbr_flag(nbr_flag),
    .out_valid(out_valid), .out_port(out_port), .out_blocked(out_blocked),
    .out_nx(out_nx), .out_ny(out_ny), .out_nz(out_nz), .out_flit(out_flit)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {pos x,y,z | dest x,y,z | flags | port | blocked | next x,y,z}
  localparam int NV = 16;
  localparam logic [31:0] VEC [NV] = '{
    {2'd1,2'd1,2'd1, 2'd2,2'd1,2'd1, 6'h00, 7'h01, 1'b0, 2'd2,2'd1,2'd1},
    {2'd1,2'd1,2'd1, 2'd0,2'd1,2'd1, 6'h00, 7'h02, 1'b0, 2'd0,2'd1,2'd1},
    {2'd1,2'd1,2'd1, 2'd1,2'd2,2'd1, 6'h00, 7'h04, 1'b0, 2'd1,2'd2,2'd1},
    {2'd1,2'd1,2'd1, 2'd1,2'd0,2'd1, 6'h00, 7'h08, 1'b0, 2'd1,2'd0,2'd1},
    {2'd1,2'd1,2'd1, 2'd1,2'd1,2'd2, 6'h00, 7'h10, 1'b0, 2'd1,2'd1,2'd2},
    {2'd1,2'd1,2'd1, 2'd1,2'd1,2'd0, 6'h00, 7'h20, 1'b0, 2'd1,2'd1,2'd0},
    {2'd1,2'd1,2'd1, 2'd1,2'd1,2'd1, 6'h00, 7'h40, 1'b0, 2'd1,2'd1,2'd1},
    {2'd0,2'd0,2'd1, 2'd2,2'd2,2'd0, 6'h00, 7'h01, 1'b0, 2'd1,2'd0,2'd1},
    {2'd2,2'd0,2'd1, 2'd2,2'd2,2'd0, 6'h04, 7'h20, 1'b0, 2'd2,2'd0,2'd0},
    {2'd0,2'd0,2'd0, 2'd2,2'd2,2'd0, 6'h01, 7'h04, 1'b0, 2'd0,2'd1,2'd0},
    {2'd0,2'd0,2'd0, 2'd2,2'd2,2'd1, 6'h05, 7'h10, 1'b0, 2'd0,2'd0,2'd1},
    {2'd0,2'd0,2'd0, 2'd2,2'd2,2'd1, 6'h15, 7'h01, 1'b1, 2'd1,2'd0,2'd0},
    {2'd1,2'd1,2'd1, 2'd1,2'd1,2'd1, 6'h3f, 7'h40, 1'b0, 2'd1,2'd1,2'd1},
    {2'd1,2'd1,2'd1, 2'd2,2'd1,2'd1, 6'h3e, 7'h01, 1'b0, 2'd2,2'd1,2'd1},
    {2'd2,2'd2,2'd2, 2'd2,2'd0,2'd2, 6'h08, 7'h08, 1'b1, 2'd2,2'd1,2'd2},
    {2'd0,2'd2,2'd1, 2'd0,2'd0,2'd0, 6'h00, 7'h08, 1'b0, 2'd0,2'd1,2'd1}
  };
  string tags [NV] = '{"R2 east", "R2 west", "R3 north", "R3 south", "R3 up", "R3 down",
                       "R4 home", "R5 x first", "R6 y flagged z taken", "R6 x flagged y taken",
                       "R6 x,y flagged z taken", "R7 all flagged", "R4 home flagged",
                       "R6 unrelated flags", "R7 single dim flagged", "R5 y before z"};

  task automatic check_reset_state(input string tag);
    check({tag, " valid"},   32'(out_valid),   32'd0);
    check({tag, " port"},    32'(out_port),    32'd0);
    check({tag, " blocked"}, 32'(out_blocked), 32'd0);
    check({tag, " next"},    32'({out_nx, out_ny, out_nz}), 32'd0);
    check({tag, " flit"},    32'(out_flit),    32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [6:0]  held_port;
    logic [21:0] held_flit;
    rst_n = 1'b0; in_valid = 1'b0; in_flit = '0;
    my_x = '0; my_y = '0; my_z = '0; nbr_flag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R10 reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      logic [7:0]  pay;
      v = VEC[i];
      pay = 8'(i * 7 + 3);
      @(negedge clk);
      {my_x, my_y, my_z} = v[31:26];
      nbr_flag = v[19:14];
      in_flit = {i[0], 7'h55, v[25:20], pay};
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({tags[i], " R9 valid"},   32'(out_valid), 32'd1);
      check({tags[i], " port"},       32'(out_port),  32'(v[13:7]));
      check({tags[i], " R7 blocked"}, 32'(out_blocked), 32'(v[6]));
      check({tags[i], " R8 next"},    32'({out_nx, out_ny, out_nz}), 32'(v[5:0]));
      check({tags[i], " R1 flit"},    32'(out_flit), 32'({i[0], v[13:7], v[25:20], pay}));
    end

    held_port = out_port;
    held_flit = out_flit;
    @(negedge clk);
    in_flit = 22'h3F_FFFF;
    nbr_flag = 6'h3f;
    my_x = 2'd0; my_y = 2'd0; my_z = 2'd0;
    @(negedge clk);
    check("R9 idle valid low",   32'(out_valid), 32'd0);
    check("R9 idle port held",   32'(out_port),  32'(held_port));
    check("R9 idle flit held",   32'(out_flit),  32'(held_flit));
    check("R9 idle next held",   32'({out_nx, out_ny, out_nz}), 32'({2'd0, 2'd1, 2'd1}));

    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R10 mid-run reset");
    rst_n = 1'b1;

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule